// File: doc/BRIEF.md
# Half-Precision to Unsigned Integer Converter

This unit turns one IEEE binary16 value into an unsigned integer of 32 or 64 bits. Results and flags are registered, so each operation has one cycle of latency and a new operand can be given every cycle. Each operation picks its own rounding mode: a default field comes from a control register, and an override field applies only when its enable is set and the operand came from a register.

The operand first passes through a classifier. It sorts the value into one of five classes: FC_ZERO, FC_SUB (subnormal), FC_NORM, FC_INF and FC_NAN. The classes are decoded with a unique case. FC_NORM and FC_SUB values are aligned onto a fixed-point grid with 24 fraction bits. A rounding stage then turns the grid value into an integer magnitude and reports whether it was exact. The top level merges the class, the sign and the magnitude into the result, the invalid flag and the precision flag. An unrepresentable result gives the all-ones indefinite pattern at the destination width.

Top module: `h2u_convert`

## Requirements
- R1: Finite non-negative inputs that are whole numbers convert exactly with no flag set, up to 65504 in both widths. The result appears one clock after the operand.
- R2: The override rounding field is used when `rc_ovr_en` and `src_is_reg` are both 1. In every other case `rc_ctl` is used.
- R3: Rounding field encoding: 00 = nearest with ties to even, 01 = toward minus infinity, 10 = toward plus infinity, 11 = toward zero.
- R4: The destination is 64 bits only when `mode64` and `opsize64` are both 1. If `mode64` is 0, `opsize64` has no effect. A 32-bit result is zero-extended, so `res[63:32]` is 0.
- R5: A finite input that is not a whole number is rounded with the selected mode and raises `flag_prec`.
- R6: A NaN (exponent field 11111 with a nonzero fraction) or an infinity of either sign raises `flag_inv`. It returns all ones at the destination width: 0xFFFFFFFF zero-extended for 32 bits, or 0xFFFFFFFFFFFFFFFF for 64 bits.
- R7: A negative input that rounds to zero returns 0 without invalid. It raises `flag_prec` only if the input was nonzero. A negative input that rounds to a nonzero value is invalid and returns the indefinite value.
- R8: `flag_prec` is never 1 while `flag_inv` is 1.
- R9: A subnormal input (exponent field 0, fraction nonzero) rounds to 0 or 1 according to mode and sign, and raises `flag_prec` unless it is invalid.
- R10: While `rst_n` is low, `res`, `flag_inv` and `flag_prec` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_h | input | 16 | binary16 operand |
| rc_ctl | input | 2 | Default rounding field from the control register |
| rc_ovr | input | 2 | Per-operation override rounding field |
| rc_ovr_en | input | 1 | Override enable |
| src_is_reg | input | 1 | Operand came from a register |
| mode64 | input | 1 | 64-bit mode active |
| opsize64 | input | 1 | Operand-size bit requesting a 64-bit destination |
| res | output | 64 | Converted result, registered |
| flag_inv | output | 1 | Invalid flag, registered |
| flag_prec | output | 1 | Precision (inexact) flag, registered |

## Verification
The assertions check on every cycle that the following hold:
- Invalid and precision are never raised together.
- A 32-bit result has a clear upper half.
- NaN and infinity give invalid with the indefinite pattern.
- A negative operand yields either zero or invalid.
- Large exact values raise no flag.
- Subnormals yield a result of 0 or 1 with precision, or else invalid.

The exact rounded value under each mode, the choice between override and default rounding, and tie-to-even decisions are shown only by the bench. The bench sweeps every binary16 encoding against an arithmetic model and adds directed cases.

// File: rtl/h2u_pkg.sv
package h2u_pkg;
    localparam int EXP_W     = 5;
    localparam int MAN_W     = 10;
    localparam int BIAS      = (1 << (EXP_W - 1)) - 1;
    localparam int FRAC_BITS = BIAS + MAN_W - 1;
    localparam int INT_W     = BIAS + 1;
    localparam int FIX_W     = FRAC_BITS + INT_W;
    localparam int IN_W      = 1 + EXP_W + MAN_W;
    localparam int RES_W     = 64;
    localparam int NARROW_W  = 32;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_DOWN = 2'b01,
        RM_UP   = 2'b10,
        RM_ZERO = 2'b11
    } rmode_e;

    typedef enum logic [2:0] {
        FC_ZERO,
        FC_SUB,
        FC_NORM,
        FC_INF,
        FC_NAN
    } fclass_e;
endpackage

// File: rtl/h2u_rm_sel.sv
module h2u_rm_sel
    import h2u_pkg::*;
(
    input  logic [1:0] rc_ctl,
    input  logic [1:0] rc_ovr,
    input  logic       rc_ovr_en,
    input  logic       src_is_reg,
    input  logic       mode64,
    input  logic       opsize64,
    output rmode_e     rmode,
    output logic       wide
);
    logic use_ovr;

    always_comb begin
        use_ovr = rc_ovr_en & src_is_reg;
        rmode   = use_ovr ? rmode_e'(rc_ovr) : rmode_e'(rc_ctl);
        // Size bit only counts in 64-bit mode
        wide    = mode64 & opsize64;
    end
endmodule

// File: rtl/h2u_classify.sv
module h2u_classify
    import h2u_pkg::*;
(
    input  logic [IN_W-1:0]  op_h,
    output fclass_e          cls,
    output logic             sign,
    output logic [FIX_W-1:0] fixed_v
);
    logic [EXP_W-1:0] expf;
    logic [MAN_W-1:0] manf;

    always_comb begin
        sign = op_h[IN_W-1];
        expf = op_h[IN_W-2 -: EXP_W];
        manf = op_h[MAN_W-1:0];
        if (expf == '1) begin
            cls = (manf == '0) ? FC_INF : FC_NAN;
        end else if (expf == '0) begin
            cls = (manf == '0) ? FC_ZERO : FC_SUB;
        end else begin
            cls = FC_NORM;
        end
    end

    // value * 2^FRAC_BITS is an exact integer for every finite input
    always_comb begin
        fixed_v = '0;
        unique case (cls)
            FC_SUB:  fixed_v = FIX_W'(manf);
            FC_NORM: fixed_v = FIX_W'({1'b1, manf}) << (expf - EXP_W'(1));
            FC_ZERO, FC_INF, FC_NAN: fixed_v = '0;
            default: fixed_v = '0;
        endcase
    end
endmodule

// File: rtl/h2u_round.sv
module h2u_round
    import h2u_pkg::*;
(
    input  logic [FIX_W-1:0] fixed_v,
    input  logic             sign,
    input  rmode_e           rmode,
    output logic [INT_W:0]   mag,
    output logic             inexact
);
    logic [INT_W-1:0] int_part;
    logic             guard;
    logic             sticky;
    logic             up;

    always_comb begin
        int_part = fixed_v[FIX_W-1:FRAC_BITS];
        guard    = fixed_v[FRAC_BITS-1];
        sticky   = |fixed_v[FRAC_BITS-2:0];
        inexact  = guard | sticky;
        unique case (rmode)
            RM_NEAR: up = guard & (sticky | int_part[0]);
            RM_DOWN: up = sign & inexact;
            RM_UP:   up = ~sign & inexact;
            RM_ZERO: up = 1'b0;
            default: up = 1'b0;
        endcase
        mag = {1'b0, int_part} + (INT_W+1)'(up);
    end
endmodule

// File: rtl/h2u_convert.sv
module h2u_convert
    import h2u_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IN_W-1:0]   op_h,
    input  logic [1:0]        rc_ctl,
    input  logic [1:0]        rc_ovr,
    input  logic              rc_ovr_en,
    input  logic              src_is_reg,
    input  logic              mode64,
    input  logic              opsize64,
    output logic [RES_W-1:0]  res,
    output logic              flag_inv,
    output logic              flag_prec
);
    localparam logic [RES_W-1:0] INDEF_W = '1;
    localparam logic [RES_W-1:0] INDEF_N =
        {{(RES_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    rmode_e            rmode;
    logic              wide;
    fclass_e           cls;
    logic              sign;
    logic [FIX_W-1:0]  fixed_v;
    logic [INT_W:0]    mag;
    logic              inexact;
    logic              special;
    logic              inv_d;
    logic              prec_d;
    logic [RES_W-1:0]  res_d;

    h2u_rm_sel u_sel (
        .rc_ctl     (rc_ctl),
        .rc_ovr     (rc_ovr),
        .rc_ovr_en  (rc_ovr_en),
        .src_is_reg (src_is_reg),
        .mode64     (mode64),
        .opsize64   (opsize64),
        .rmode      (rmode),
        .wide       (wide)
    );

    h2u_classify u_cls (
        .op_h    (op_h),
        .cls     (cls),
        .sign    (sign),
        .fixed_v (fixed_v)
    );

    h2u_round u_rnd (
        .fixed_v (fixed_v),
        .sign    (sign),
        .rmode   (rmode),
        .mag     (mag),
        .inexact (inexact)
    );

    always_comb begin
        unique case (cls)
            FC_INF, FC_NAN:          special = 1'b1;
            FC_ZERO, FC_SUB, FC_NORM: special = 1'b0;
            default:                 special = 1'b1;
        endcase
        inv_d  = special | (sign & (mag != '0));
        prec_d = inexact & ~inv_d;
        if (inv_d) begin
            res_d = wide ? INDEF_W : INDEF_N;
        end else begin
            res_d = RES_W'(mag);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res       <= '0;
            flag_inv  <= 1'b0;
            flag_prec <= 1'b0;
        end else begin
            res       <= res_d;
            flag_inv  <= inv_d;
            flag_prec <= prec_d;
        end
    end
endmodule

// File: rtl/h2u_convert_chk.sv
module h2u_convert_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] op_h,
    input logic        mode64,
    input logic        opsize64,
    input logic [63:0] res,
    input logic        flag_inv,
    input logic        flag_prec
);
    p_inv_no_prec_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flag_inv |-> !flag_prec);

    p_narrow_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mode64 && opsize64) |=> (res[63:32] == 32'h0));

    p_special_indef_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_h[14:10] == 5'h1f) |=> (flag_inv && res[31:0] == 32'hFFFF_FFFF));

    p_neg_zero_or_inv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        op_h[15] |=> (flag_inv || res == 64'h0));

    p_big_exact_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_h[15] && op_h[14:10] >= 5'd25 && op_h[14:10] != 5'h1f)
        |=> (!flag_prec && !flag_inv));

    p_subnorm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_h[14:10] == 5'h0 && op_h[9:0] != 10'h0)
        |=> (flag_prec ? (res[63:1] == 63'h0) : flag_inv));
endmodule

bind h2u_convert h2u_convert_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_h      (op_h),
    .mode64    (mode64),
    .opsize64  (opsize64),
    .res       (res),
    .flag_inv  (flag_inv),
    .flag_prec (flag_prec)
);

// File: tb/sim_h2u_convert.sv
`timescale 1ns/1ps
module sim_h2u_convert;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] op_h = '0;
    logic [1:0]  rc_ctl = '0;
    logic [1:0]  rc_ovr = '0;
    logic        rc_ovr_en = 1'b0;
    logic        src_is_reg = 1'b0;
    logic        mode64 = 1'b0;
    logic        opsize64 = 1'b0;
    logic [63:0] res;
    logic        flag_inv;
    logic        flag_prec;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    h2u_convert u0 (.*);

    // Arithmetic reference: value * 2^24 as an integer, then divide.
    function automatic void model(input logic [15:0] op, input logic [1:0] rm,
                                  input logic wide, output logic [63:0] r,
                                  output logic inv, output logic pr);
        int e;
        longint f, fx, q, rem;
        logic neg, up;
        e = int'(op[14:10]);
        f = longint'(op[9:0]);
        neg = op[15];
        inv = 0; pr = 0; r = 0;
        if (e == 31) begin
            inv = 1;
        end else begin
            fx  = (e == 0) ? f : ((1024 + f) << (e - 1));
            q   = fx / 64'd16777216;
            rem = fx % 64'd16777216;
            case (rm)
                2'd0: up = (rem > 8388608) || (rem == 8388608 && (q % 2) == 1);
                2'd1: up = neg && rem != 0;
                2'd2: up = !neg && rem != 0;
                default: up = 0;
            endcase
            if (up) q = q + 1;
            if (neg && q != 0) inv = 1;
            else begin
                r  = neg ? 64'd0 : 64'(q);
                pr = (rem != 0);
            end
        end
        if (inv) r = wide ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp_v);
        end
    endtask

    // Entered at a negedge, leaves at the following negedge.
    task automatic apply(input logic [15:0] op, input logic [1:0] ctl, input logic [1:0] ovr,
                         input logic en, input logic rg, input logic m64, input logic sz,
                         input string req);
        logic [63:0] er;
        logic ei, ep;
        op_h = op; rc_ctl = ctl; rc_ovr = ovr; rc_ovr_en = en;
        src_is_reg = rg; mode64 = m64; opsize64 = sz;
        model(op, (en && rg) ? ovr : ctl, m64 && sz, er, ei, ep);
        @(negedge clk);
        chk(req, {res, flag_inv, flag_prec}, {er, ei, ep});
    endtask

    function automatic string tag_of(input logic [15:0] op);
        if (op[14:10] == 5'h1f) return "R6 special";
        if (op[15] && op[14:0] != 0) return "R7 negative";
        if (op[14:10] == 0 && op[9:0] != 0) return "R9 subnormal";
        if (op[14:10] < 5'd25) return "R5/R3 rounding";
        return "R1 exact";
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R10: reset state with live inputs
        op_h = 16'h7C00; mode64 = 1; opsize64 = 1;
        repeat (3) @(negedge clk);
        chk("R10 reset", {res, flag_inv, flag_prec}, 66'h0);
        rst_n = 1;
        @(negedge clk);

        // R1: largest finite value, both widths
        apply(16'h7BFF, 2'd0, 2'd0, 0, 0, 1, 1, "R1 max wide");
        chk("R1 max wide value", res, 64'd65504);
        apply(16'h7BFF, 2'd2, 2'd0, 0, 0, 0, 0, "R1 max narrow");
        chk("R1 max narrow value", res, 64'd65504);
        apply(16'h3C00, 2'd3, 2'd0, 0, 0, 0, 0, "R1 one");

        // R2: override only with enable and register source
        apply(16'h3E00, 2'd3, 2'd2, 1, 0, 0, 0, "R2 override ignored");
        chk("R2 ctl used", res, 64'd1);
        apply(16'h3E00, 2'd3, 2'd2, 1, 1, 0, 0, "R2 override taken");
        chk("R2 ovr used", res, 64'd2);
        apply(16'h3E00, 2'd3, 2'd2, 0, 1, 0, 0, "R2 enable low");
        chk("R2 enable low", res, 64'd1);

        // R3: ties to even
        apply(16'h3800, 2'd0, 2'd0, 0, 0, 0, 0, "R3 0.5 near");
        chk("R3 0.5 to 0", res, 64'd0);
        apply(16'h4100, 2'd0, 2'd0, 0, 0, 0, 0, "R3 2.5 near");
        chk("R3 2.5 to 2", res, 64'd2);
        apply(16'h3E00, 2'd0, 2'd0, 0, 0, 0, 0, "R3 1.5 near");
        chk("R3 1.5 to 2", res, 64'd2);

        // R4: size bit ignored outside 64-bit mode
        apply(16'h7E00, 2'd0, 2'd0, 0, 0, 0, 1, "R4 narrow nan");
        chk("R4 narrow indef", res, 64'h0000_0000_FFFF_FFFF);
        apply(16'h7E00, 2'd0, 2'd0, 0, 0, 1, 1, "R4 wide nan");
        chk("R4 wide indef", res, 64'hFFFF_FFFF_FFFF_FFFF);

        // R6 / R7 / R8 / R9 corners
        apply(16'hFC00, 2'd0, 2'd0, 0, 0, 1, 1, "R6 minus inf");
        apply(16'hB666, 2'd0, 2'd0, 0, 0, 0, 0, "R7 -0.4 near");
        chk("R7 -0.4 flags", {flag_inv, flag_prec}, 2'b01);
        apply(16'hB666, 2'd1, 2'd0, 0, 0, 0, 0, "R8 -0.4 down");
        chk("R8 inv without prec", {flag_inv, flag_prec}, 2'b10);
        apply(16'h8000, 2'd1, 2'd0, 0, 0, 0, 0, "R7 minus zero");
        chk("R7 minus zero flags", {res, flag_inv, flag_prec}, 66'h0);
        apply(16'h0001, 2'd2, 2'd0, 0, 0, 0, 0, "R9 tiny up");
        chk("R9 tiny up value", res, 64'd1);
        apply(16'h8001, 2'd2, 2'd0, 0, 0, 0, 0, "R9 neg tiny up");
        chk("R9 neg tiny flags", {res, flag_inv, flag_prec}, 66'h1);

        // Full sweep of every encoding with varied configuration
        for (int i = 0; i < 65536; i++) begin
            logic [31:0] h;
            h = 32'(i) * 32'h9E37_79B1;
            apply(16'(i), h[31:30], h[29:28], h[27], h[26], h[25], h[24], tag_of(16'(i)));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule